// File: doc/BRIEF.md
# Ethernet Controller Control/Status Register File

This block is the host-visible register file of a network controller. The host sees only two 16-bit words. Writing the address word picks a register number. Reading or writing the data word then acts on that register. The file holds several registers:

- the main command/status word, whose bits mix set-on-write, read-only, read/write and write-one-to-clear behaviour;
- the two halves of the initialisation-block address;
- a bus-control register;
- four 16-bit multicast filter words;
- a promiscuous-mode flag.

The transmit and receive engines report events through single-cycle pulses. These pulses set sticky flags in the status word. The block combines the flags into a level interrupt, gated by an enable bit. A stop command puts the controller in a quiet state: it clears the run state and the flags, and it forces the bus-control byte-swap bit back to little-endian. The configuration registers can be changed only while the controller is stopped. The block drives the run/stop/init control levels, a one-cycle transmit-demand strobe and the configuration values to the engines.

Top module: `enet_csr_file`

## Requirements
- R1: A write to the address port (`hostSel`=1) stores `hostWdata[3:0]` as the selected register number, and reading the address port returns it zero-extended. Data-port accesses (`hostSel`=0) act on the selected register. Register numbers 4-7 and 12-14 read as zero and ignore writes.
- R2: After reset the status word (register 0) reads 0x0004 (stopped only), every configuration output is zero, the selected register is 0 and `irqOut` is low.
- R3: In register 0, writing 1 to bit 1 (start) sets the start bit and the transmitter-on and receiver-on bits (bits 4 and 5) and clears the stop bit (bit 2). Writing 1 to bit 0 (init) sets init and clears stop. Start and init stay set until a stop. Writes to bits 4, 5, 7 and 15 have no effect.
- R4: A register-0 write with bit 2 set wins over every other bit of that write. The word then reads 0x0004: init, start, transmit demand, transmitter-on, receiver-on, interrupt enable and flags 8-14 are all cleared. The same write clears the byte-swap bit (bit 2) of register 3.
- R5: Writing 1 to bit 3 of register 0 without a stop raises `txDemand` for one cycle. Bit 3 reads 1 during that cycle only.
- R6: Bit 6 of register 0 (interrupt enable) takes the written value on every register-0 write that does not carry a stop.
- R7: The `evPulse` bits 0-6 set flag bits 8-14 of register 0, in the order init-done, tx-done, rx-done, memory error, missed frame, carrier error, babble. A pulse sets its flag only while stop is clear. Writing 1 to a flag bit clears it, and a pulse in the same cycle wins over the clear.
- R8: Bit 7 of register 0 reads as the OR of flags 8-14. `irqOut` is high exactly when bit 7 and bit 6 are both 1.
- R9: Bit 15 of register 0 reads as the OR of the memory-error, missed-frame, carrier-error and babble flags (bits 11-14).
- R10: Registers 1 and 2 form the low and high halves of `cfgInitAddr`. Bits 2:0 of register 3 drive `cfgBusCtl` (byte swap, address-latch control, byte control). Registers 8-11 are filter words 0-3, with register 8 in `cfgFilter[15:0]`. Bit 15 of register 15 drives `cfgPromisc`, and the other bits of register 15 read 0.
- R11: Writes to registers 1, 2, 3, 8-11 and 15 take effect only while stop is set and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe, one write per cycle held high |
| hostSel | input | 1 | Port select: 1 address port, 0 data port |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data of the selected port (combinational) |
| evPulse | input | 7 | Engine event pulses, bit i sets flag bit 8+i |
| irqOut | output | 1 | Level interrupt |
| ctlInit | output | 1 | Init command level |
| ctlStop | output | 1 | Controller stopped |
| txOn | output | 1 | Transmitter enabled |
| rxOn | output | 1 | Receiver enabled |
| txDemand | output | 1 | One-cycle transmit poll strobe |
| cfgInitAddr | output | 32 | Initialisation-block address |
| cfgBusCtl | output | 3 | Bus control: byte swap, address-latch control, byte control |
| cfgFilter | output | 64 | Multicast filter |
| cfgPromisc | output | 1 | Promiscuous mode enable |

## Verification
Two situations are the hardest to reach from the ports. The first is a flag clear and an engine pulse for the same flag landing in the same cycle. The second is a configuration write attempted while the controller runs, which needs the selected register, the run state and the data word lined up together. The directed part of the bench places a write-one-to-clear and a matching pulse in one cycle, and it aims a config write at a running controller. The random part then interleaves address selections, data writes with a biased chance of carrying a stop, and event bursts. This way the controller keeps crossing between stopped and running phases while config registers are selected.

// File: rtl/enet_csr_pkg.sv
package enet_csr_pkg;
  parameter int DATA_W     = 16;
  parameter int REG_W      = 4;
  parameter int FILT_WORDS = 4;
  parameter int FLAG_N     = 7;
  parameter int BUS_W      = 3;

  localparam int FILT_W = FILT_WORDS * DATA_W;
  localparam int ADDR_W = 2 * DATA_W;

  // register numbers
  localparam logic [REG_W-1:0] REG_CSR0    = 4'd0;
  localparam logic [REG_W-1:0] REG_IADR_LO = 4'd1;
  localparam logic [REG_W-1:0] REG_IADR_HI = 4'd2;
  localparam logic [REG_W-1:0] REG_BUS     = 4'd3;
  localparam logic [REG_W-1:0] REG_FILT0   = 4'd8;
  localparam logic [REG_W-1:0] REG_PROM    = 4'd15;

  // status word bit positions
  localparam int B_INIT  = 0;
  localparam int B_STRT  = 1;
  localparam int B_STOP  = 2;
  localparam int B_TDMD  = 3;
  localparam int B_INEA  = 6;
  localparam int B_FLAG0 = 8;
  // flag index of the first error-class flag
  localparam int F_ERR0  = 3;
  // bus-control byte-swap bit
  localparam int B_BSWP  = 2;

  typedef struct packed {
    logic                  csrWr;
    logic                  iadrLoWr;
    logic                  iadrHiWr;
    logic                  busWr;
    logic [FILT_WORDS-1:0] filtWr;
    logic                  promWr;
  } csrStrobes_t;
endpackage

// File: rtl/enet_csr_ctrl.sv
module enet_csr_ctrl
  import enet_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic             hostSel,
  input  logic [REG_W-1:0] addrIn,
  input  logic             stopBit,
  output logic [REG_W-1:0] regSel,
  output csrStrobes_t      strb
);
  logic                  dataWr;
  logic                  cfgWr;
  logic [FILT_WORDS-1:0] filtHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regSel <= '0;
    else if (hostWe && hostSel) regSel <= addrIn;
  end

  assign dataWr = hostWe && !hostSel;
  // configuration writes are accepted only while stopped
  assign cfgWr  = dataWr && stopBit;

  for (genvar gi = 0; gi < FILT_WORDS; gi++) begin : g_filtHit
    assign filtHit[gi] = cfgWr && (regSel == REG_W'(REG_FILT0 + gi));
  end

  always_comb begin
    strb.csrWr    = dataWr && (regSel == REG_CSR0);
    strb.iadrLoWr = cfgWr && (regSel == REG_IADR_LO);
    strb.iadrHiWr = cfgWr && (regSel == REG_IADR_HI);
    strb.busWr    = cfgWr && (regSel == REG_BUS);
    strb.filtWr   = filtHit;
    strb.promWr   = cfgWr && (regSel == REG_PROM);
  end
endmodule

// File: rtl/enet_csr_dpath.sv
module enet_csr_dpath
  import enet_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobes_t       strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_W-1:0]  regSel,
  input  logic              hostSel,
  input  logic [FLAG_N-1:0] evPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              stopBit,
  output logic              irqOut,
  output logic              initBit,
  output logic              txOn,
  output logic              rxOn,
  output logic              txDemand,
  output logic [ADDR_W-1:0] cfgInitAddr,
  output logic [BUS_W-1:0]  cfgBusCtl,
  output logic [FILT_W-1:0] cfgFilter,
  output logic              cfgPromisc
);
  logic              strt;
  logic              inea;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] clrMask;
  logic [FLAG_N-1:0] setMask;
  logic              stopCmd;
  logic              intr;
  logic              errSum;
  logic [DATA_W-1:0] csr0;
  logic [DATA_W-1:0] iadrLo;
  logic [DATA_W-1:0] iadrHi;
  logic [BUS_W-1:0]  busCtl;
  logic              promisc;
  logic [DATA_W-1:0] filtWord [FILT_WORDS];

  assign stopCmd = strb.csrWr && wdata[B_STOP];
  assign clrMask = strb.csrWr ? wdata[B_FLAG0 +: FLAG_N] : '0;
  // engines may raise flags only while running
  assign setMask = stopBit ? '0 : evPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initBit  <= 1'b0;
      strt     <= 1'b0;
      stopBit  <= 1'b1;
      txDemand <= 1'b0;
      txOn     <= 1'b0;
      rxOn     <= 1'b0;
      inea     <= 1'b0;
      flags    <= '0;
    end else if (stopCmd) begin
      initBit  <= 1'b0;
      strt     <= 1'b0;
      stopBit  <= 1'b1;
      txDemand <= 1'b0;
      txOn     <= 1'b0;
      rxOn     <= 1'b0;
      inea     <= 1'b0;
      flags    <= '0;
    end else begin
      txDemand <= strb.csrWr && wdata[B_TDMD];
      if (strb.csrWr) begin
        inea <= wdata[B_INEA];
        if (wdata[B_STRT]) begin
          strt    <= 1'b1;
          txOn    <= 1'b1;
          rxOn    <= 1'b1;
          stopBit <= 1'b0;
        end
        if (wdata[B_INIT]) begin
          initBit <= 1'b1;
          stopBit <= 1'b0;
        end
      end
      flags <= (flags & ~clrMask) | setMask;
    end
  end

  assign intr   = |flags;
  assign errSum = |flags[FLAG_N-1:F_ERR0];
  assign irqOut = intr && inea;
  assign csr0   = {errSum, flags, intr, inea, rxOn, txOn, txDemand, stopBit, strt, initBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iadrLo  <= '0;
      iadrHi  <= '0;
      promisc <= 1'b0;
    end else begin
      if (strb.iadrLoWr) iadrLo <= wdata;
      if (strb.iadrHiWr) iadrHi <= wdata;
      if (strb.promWr) promisc <= wdata[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busCtl <= '0;
    else if (stopCmd) busCtl[B_BSWP] <= 1'b0;
    else if (strb.busWr) busCtl <= wdata[BUS_W-1:0];
  end

  for (genvar gi = 0; gi < FILT_WORDS; gi++) begin : g_filt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) filtWord[gi] <= '0;
      else if (strb.filtWr[gi]) filtWord[gi] <= wdata;
    end
    assign cfgFilter[gi*DATA_W +: DATA_W] = filtWord[gi];
  end

  assign cfgInitAddr = {iadrHi, iadrLo};
  assign cfgBusCtl   = busCtl;
  assign cfgPromisc  = promisc;

  always_comb begin
    rdData = '0;
    if (hostSel) begin
      rdData = DATA_W'(regSel);
    end else begin
      case (regSel)
        REG_CSR0:    rdData = csr0;
        REG_IADR_LO: rdData = iadrLo;
        REG_IADR_HI: rdData = iadrHi;
        REG_BUS:     rdData = DATA_W'(busCtl);
        REG_PROM:    rdData = {promisc, {(DATA_W-1){1'b0}}};
        default:     rdData = '0;
      endcase
      for (int i = 0; i < FILT_WORDS; i++) begin
        if (regSel == REG_W'(REG_FILT0 + i)) rdData = filtWord[i];
      end
    end
  end
endmodule

// File: rtl/enet_csr_file.sv
module enet_csr_file
  import enet_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [FLAG_N-1:0] evPulse,
  output logic              irqOut,
  output logic              ctlInit,
  output logic              ctlStop,
  output logic              txOn,
  output logic              rxOn,
  output logic              txDemand,
  output logic [ADDR_W-1:0] cfgInitAddr,
  output logic [BUS_W-1:0]  cfgBusCtl,
  output logic [FILT_W-1:0] cfgFilter,
  output logic              cfgPromisc
);
  csrStrobes_t      strb;
  logic [REG_W-1:0] regSel;

  enet_csr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWe  (hostWe),
    .hostSel (hostSel),
    .addrIn  (hostWdata[REG_W-1:0]),
    .stopBit (ctlStop),
    .regSel  (regSel),
    .strb    (strb)
  );

  enet_csr_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wdata       (hostWdata),
    .regSel      (regSel),
    .hostSel     (hostSel),
    .evPulse     (evPulse),
    .rdData      (hostRdata),
    .stopBit     (ctlStop),
    .irqOut      (irqOut),
    .initBit     (ctlInit),
    .txOn        (txOn),
    .rxOn        (rxOn),
    .txDemand    (txDemand),
    .cfgInitAddr (cfgInitAddr),
    .cfgBusCtl   (cfgBusCtl),
    .cfgFilter   (cfgFilter),
    .cfgPromisc  (cfgPromisc)
  );
endmodule

// File: rtl/enet_csr_chk.sv
module enet_csr_chk
  import enet_csr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostWe,
  input logic              hostSel,
  input logic [DATA_W-1:0] hostWdata,
  input logic              irqOut,
  input logic              ctlInit,
  input logic              ctlStop,
  input logic              txOn,
  input logic              rxOn,
  input logic              txDemand,
  input logic [ADDR_W-1:0] cfgInitAddr,
  input logic [BUS_W-1:0]  cfgBusCtl,
  input logic [FILT_W-1:0] cfgFilter,
  input logic              cfgPromisc
);
  logic [REG_W-1:0] ptrC;
  logic             csrWrC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrC <= '0;
    else if (hostWe && hostSel) ptrC <= hostWdata[REG_W-1:0];
  end
  assign csrWrC = hostWe && !hostSel && (ptrC == REG_CSR0);

  // R4: stop command forces the quiet state on the next cycle
  p_stop_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrC && hostWdata[B_STOP]) |=>
      (ctlStop && !txOn && !rxOn && !ctlInit && !irqOut && !cfgBusCtl[B_BSWP]));

  // R4: byte swap only drops when the controller is stopped
  p_bswp_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgBusCtl[B_BSWP]) |-> ctlStop);

  // R3: start without stop turns both engines on
  p_run_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrC && hostWdata[B_STRT] && !hostWdata[B_STOP]) |=> (txOn && rxOn && !ctlStop));

  // R3: stopped implies engines off and no interrupt (R8)
  p_stopped_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctlStop |-> (!txOn && !rxOn && !irqOut));

  // R5: transmit demand is a single-cycle strobe
  p_tdmd_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    txDemand |=> !txDemand);

  // R11: configuration cannot change while running
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctlStop |=> ($stable(cfgInitAddr) && $stable(cfgFilter) && $stable(cfgPromisc)));
endmodule

bind enet_csr_file enet_csr_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostWe      (hostWe),
  .hostSel     (hostSel),
  .hostWdata   (hostWdata),
  .irqOut      (irqOut),
  .ctlInit     (ctlInit),
  .ctlStop     (ctlStop),
  .txOn        (txOn),
  .rxOn        (rxOn),
  .txDemand    (txDemand),
  .cfgInitAddr (cfgInitAddr),
  .cfgBusCtl   (cfgBusCtl),
  .cfgFilter   (cfgFilter),
  .cfgPromisc  (cfgPromisc)
);

// File: tb/enet_csr_file_bench.sv
module enet_csr_file_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWe;
  logic        hostSel;
  logic [15:0] hostWdata;
  logic [15:0] hostRdata;
  logic [6:0]  evPulse;
  logic        irqOut, ctlInit, ctlStop, txOn, rxOn, txDemand, cfgPromisc;
  logic [31:0] cfgInitAddr;
  logic [2:0]  cfgBusCtl;
  logic [63:0] cfgFilter;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [3:0]  mPtr;
  bit          mInit, mStrt, mStop, mTdmd, mInea, mProm;
  logic [6:0]  mFlags;
  logic [15:0] mLo, mHi;
  logic [2:0]  mBus;
  logic [15:0] mFilt [4];

  always #5 clk = ~clk;

  enet_csr_file u_enet_csr_file (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .evPulse(evPulse),
    .irqOut(irqOut), .ctlInit(ctlInit), .ctlStop(ctlStop), .txOn(txOn),
    .rxOn(rxOn), .txDemand(txDemand), .cfgInitAddr(cfgInitAddr),
    .cfgBusCtl(cfgBusCtl), .cfgFilter(cfgFilter), .cfgPromisc(cfgPromisc)
  );

  function automatic logic [15:0] expRead(input logic [3:0] p);
    case (p)
      4'd0: return {|mFlags[6:3], mFlags, |mFlags, mInea, mStrt, mStrt, mTdmd, mStop, mStrt, mInit};
      4'd1: return mLo;
      4'd2: return mHi;
      4'd3: return {13'd0, mBus};
      4'd8, 4'd9, 4'd10, 4'd11: return mFilt[p - 4'd8];
      4'd15: return {mProm, 15'd0};
      default: return 16'd0;
    endcase
  endfunction

  function automatic bit expIrq();
    return (|mFlags) && mInea;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [15:0] d, input logic [6:0] ev);
    logic [6:0] setM;
    setM = mStop ? 7'd0 : ev;
    if (mPtr == 4'd0) begin
      if (d[2]) begin
        mInit = 0; mStrt = 0; mStop = 1; mTdmd = 0; mInea = 0;
        mFlags = 7'd0; mBus[2] = 1'b0;
      end else begin
        mInea = d[6];
        if (d[1]) begin mStrt = 1; mStop = 0; end
        if (d[0]) begin mInit = 1; mStop = 0; end
        mTdmd = d[3];
        mFlags = (mFlags & ~d[14:8]) | setM;
      end
    end else begin
      mFlags = mFlags | setM;
      if (mStop) begin
        case (mPtr)
          4'd1: mLo = d;
          4'd2: mHi = d;
          4'd3: mBus = d[2:0];
          4'd8, 4'd9, 4'd10, 4'd11: mFilt[mPtr - 4'd8] = d;
          4'd15: mProm = d[15];
          default: ;
        endcase
      end
    end
  endtask

  task automatic wrAddr(input logic [3:0] n);
    @(negedge clk);
    mTdmd = 0;
    hostWe = 1; hostSel = 1; hostWdata = {12'hA5C, n};
    @(negedge clk);
    hostWe = 0; hostSel = 0;
    mPtr = n;
  endtask

  task automatic wrData(input logic [15:0] d, input logic [6:0] ev);
    @(negedge clk);
    mTdmd = 0;
    hostWe = 1; hostSel = 0; hostWdata = d; evPulse = ev;
    @(negedge clk);
    hostWe = 0; evPulse = 7'd0;
    modelWrite(d, ev);
  endtask

  task automatic pulse(input logic [6:0] ev);
    @(negedge clk);
    mTdmd = 0;
    evPulse = ev;
    @(negedge clk);
    evPulse = 7'd0;
    if (!mStop) mFlags = mFlags | ev;
  endtask

  task automatic idle();
    @(negedge clk);
    mTdmd = 0;
  endtask

  task automatic readData(output logic [15:0] v);
    hostSel = 0; #1; v = hostRdata;
  endtask

  task automatic checkAll();
    hostSel = 0; #1;
    chk("R1 data read", {48'd0, hostRdata}, {48'd0, expRead(mPtr)});
    chk("R8 irq", {63'd0, irqOut}, {63'd0, expIrq()});
    chk("R3 run levels", {61'd0, txOn, rxOn, ctlInit}, {61'd0, mStrt, mStrt, mInit});
    chk("R4 stop level", {63'd0, ctlStop}, {63'd0, mStop});
    chk("R5 demand", {63'd0, txDemand}, {63'd0, mTdmd});
    chk("R10 init addr", {32'd0, cfgInitAddr}, {32'd0, mHi, mLo});
    chk("R10 bus ctl", {61'd0, cfgBusCtl}, {61'd0, mBus});
    chk("R10 filter", cfgFilter, {mFilt[3], mFilt[2], mFilt[1], mFilt[0]});
    chk("R10 promisc", {63'd0, cfgPromisc}, {63'd0, mProm});
    hostSel = 1; #1;
    chk("R1 addr read", {48'd0, hostRdata}, {60'd0, mPtr});
    hostSel = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2024);
    rstN = 0; hostWe = 0; hostSel = 0; hostWdata = 16'd0; evPulse = 7'd0;
    mPtr = 0; mInit = 0; mStrt = 0; mStop = 1; mTdmd = 0; mInea = 0; mProm = 0;
    mFlags = 0; mLo = 0; mHi = 0; mBus = 0;
    for (int i = 0; i < 4; i++) mFilt[i] = 16'd0;
    repeat (3) @(negedge clk);
    rstN = 1;
    idle();

    // R2 reset state
    checkAll();
    readData(v); chk("R2 reset status", {48'd0, v}, 64'h0004);
    chk("R2 reset irq", {63'd0, irqOut}, 64'd0);

    // R4 init together with stop reads as stop only
    wrAddr(4'd0);
    wrData(16'h0005, 7'd0);
    readData(v); chk("R4 init+stop", {48'd0, v}, 64'h0004);
    checkAll();

    // R7 events ignored while stopped
    pulse(7'h7F);
    readData(v); chk("R7 stopped events", {48'd0, v}, 64'h0004);

    // R10 config while stopped
    wrAddr(4'd1); wrData(16'hBEEF, 7'd0);
    wrAddr(4'd2); wrData(16'h00A5, 7'd0);
    chk("R10 init addr value", {32'd0, cfgInitAddr}, 64'h00A5BEEF);
    wrAddr(4'd3); wrData(16'hFFFF, 7'd0);
    chk("R10 bus value", {61'd0, cfgBusCtl}, 64'd7);
    wrAddr(4'd15); wrData(16'h7FFF, 7'd0);
    readData(v); chk("R10 promisc low bits", {48'd0, v}, 64'd0);
    wrData(16'h8000, 7'd0);
    readData(v); chk("R10 promisc set", {48'd0, v}, 64'h8000);
    wrAddr(4'd9); wrData(16'h1357, 7'd0);
    chk("R10 filter word1", {48'd0, cfgFilter[31:16]}, 64'h1357);
    wrAddr(4'd5); wrData(16'hFFFF, 7'd0);
    readData(v); chk("R1 unmapped", {48'd0, v}, 64'd0);
    checkAll();

    // R3 / R6 start with interrupt enable
    wrAddr(4'd0); wrData(16'h00F2, 7'd0);
    readData(v); chk("R3 R6 start", {48'd0, v}, 64'h0072);

    // R11 config write ignored while running
    wrAddr(4'd1); wrData(16'h1234, 7'd0);
    readData(v); chk("R11 frozen", {48'd0, v}, 64'hBEEF);
    checkAll();
    wrAddr(4'd0);

    // R7 / R8 tx-done event
    pulse(7'b0000010);
    readData(v); chk("R7 tint", {48'd0, v}, 64'h02F2);
    chk("R8 irq on", {63'd0, irqOut}, 64'd1);
    // R9 memory error raises summary
    pulse(7'b0001000);
    readData(v); chk("R9 summary", {48'd0, v}, 64'h8AF2);
    // R7 clear plus same-cycle event: event wins
    wrData(16'h0A40, 7'b0000010);
    readData(v); chk("R7 event beats clear", {48'd0, v}, 64'h02F2);
    // R6 / R8 enable off masks irq
    wrData(16'h0000, 7'd0);
    readData(v); chk("R6 inea off", {48'd0, v}, 64'h02B2);
    chk("R8 irq masked", {63'd0, irqOut}, 64'd0);
    wrData(16'h0200, 7'd0);
    readData(v); chk("R7 cleared", {48'd0, v}, 64'h0032);
    checkAll();

    // R5 transmit demand pulse
    wrData(16'h0008, 7'd0);
    chk("R5 demand high", {63'd0, txDemand}, 64'd1);
    readData(v); chk("R5 bit3 visible", {48'd0, v}, 64'h003A);
    idle();
    chk("R5 demand low", {63'd0, txDemand}, 64'd0);
    readData(v); chk("R5 bit3 gone", {48'd0, v}, 64'h0032);

    // R3 init while running
    wrData(16'h0001, 7'd0);
    readData(v); chk("R3 init", {48'd0, v}, 64'h0033);

    // R4 stop clears byte swap only
    wrData(16'h0004, 7'd0);
    readData(v); chk("R4 stop", {48'd0, v}, 64'h0004);
    chk("R4 bswp cleared", {61'd0, cfgBusCtl}, 64'd3);
    checkAll();

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [15:0] d;
      logic [6:0] ev;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [3:0] pick [13];
        pick = '{4'd0, 4'd0, 4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd15, 4'd5, 4'd12};
        wrAddr(pick[$urandom_range(0, 12)]);
      end else if (op < 7) begin
        d = 16'($urandom);
        if ($urandom_range(0, 3) != 0) d[2] = 1'b0;
        ev = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'd0;
        wrData(d, ev);
      end else if (op < 9) begin
        pulse(7'($urandom));
      end else begin
        idle();
      end
      checkAll();
    end

    finishRun();
  end
endmodule